// File: doc/BRIEF.md
# Serialized Interrupt Frame Agent

This block is the peripheral end of a single-wire, open-drain serialized interrupt line running on the bus clock. It watches the shared line for a host start frame. It then steps through a fixed train of 21 data frames, each three clocks long. In every frame that carries one of its asserted interrupts, it pulls the line low and then drives it high for one recovery clock. The report covers ISA-style request lines, a system-management request, a channel-check request and four PCI-style interrupts.

The PCI interrupts pass through a small configuration network before they reach their frames. A merge-all control folds every PCI interrupt into the first PCI frame. A socket-merge control folds the two card-socket interrupts into that same frame. A two-bit step control rotates the four PCI interrupts among the four PCI frames.

The width of the stop frame sets the mode of the next cycle. In quiet mode the agent may start a cycle itself by pulling the idle line low for one clock. The host frame generator is outside this block, and so is the decoding of the configuration registers.

Top module: `sirq_agent`

## Requirements
- R1: After reset the line is not driven (line_oe=0) and the agent is in continuous mode: a change on an interrupt input while the line is idle produces no drive.
- R2: A start frame is recognised when the line reads low on 4 or more consecutive clocks and then high. Widths of 4 to 8 clocks are all accepted. A run of 3 lows is ignored, and no data frame is driven after it. The clock that first reads high is followed by one turnaround clock, and then the sample phase of frame 0 begins.
- R3: Frame order is fixed. Frame n carries isa_irq[n] for n=0..15, where bit 2 is the system-management request. Frame 16 carries iochk_req. Frames 17 to 20 carry the four PCI interrupts INTA to INTD (pci_int[0] to pci_int[3]) when step=0 and no merge is set.
- R4: In each frame whose reported bit is 1, the agent drives low in the sample clock and high in the recovery clock, then releases the line in the turnaround clock. Frames whose reported bit is 0 are never driven.
- R5: The reported vector is captured when the start frame is recognised. Input changes during the data frames do not alter that cycle's report.
- R6: A stop frame of 2 low clocks sets quiet mode and a stop frame of 3 low clocks sets continuous mode. Any other stop width leaves the mode unchanged.
- R7: In quiet mode, when the mapped inputs differ from the last report and the line is idle, the agent drives low (line_oe=1, line_out=0) for exactly one clock. It does not do so again until the next start frame is recognised.
- R8: In continuous mode the agent never requests a cycle.
- R9: With tie_all=1, the OR of all four PCI interrupts is reported as INTA and INTB to INTD report 0. This takes precedence over cb_tie.
- R10: With cb_tie=1 (and tie_all=0), pci_int[0] OR pci_int[1] is reported as INTA, INTB reports 0, and INTC and INTD pass unchanged.
- R11: After merging, PCI interrupt x (0=INTA) is reported in frame 17+((x+step) mod 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Level of the shared serialized line |
| isa_irq | input | 16 | ISA-style requests; bit 2 is the system-management request |
| iochk_req | input | 1 | Channel-check request |
| pci_int | input | 4 | PCI-style interrupts INTA..INTD in bits 0..3 |
| tie_all | input | 1 | Merge all PCI interrupts into INTA |
| cb_tie | input | 1 | Merge the two socket interrupts (bits 0,1) into INTA |
| step | input | 2 | Rotation of the PCI interrupts among frames 17..20 |
| line_oe | output | 1 | Drive enable for the line |
| line_out | output | 1 | Value driven when line_oe is 1 |

## Verification
The assertions check on every clock the properties that follow from state alone. The frame index stays inside the 21-frame train. One turnaround clock always leads into the sample phase of frame 0. The mode only changes as a stop frame completes. The line is released in every turnaround phase. A quiet request lasts one clock and never occurs outside quiet mode. The bench scenarios are needed for the rest, because those depend on what the host does across a whole cycle: the frame-to-input mapping under every merge and step setting, the range of accepted start widths, rejection of a short start, the snapshot under mid-cycle input changes, and the decoding of stop widths followed by request or silence in the next idle period.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int SLOTS     = 21;
    localparam int SLOT_W    = 5;
    localparam int ISA_LINES = 16;
    localparam int PCI_LINES = 4;
    localparam int STEP_W    = 2;

    typedef enum logic [1:0] {
        TRK_IDLE,
        TRK_START_TA,
        TRK_DATA,
        TRK_STOP
    } trk_state_e;

    typedef enum logic [1:0] {
        PH_SAMPLE,
        PH_RECOVER,
        PH_TURN
    } phase_e;

    typedef enum logic {
        MODE_CONT,
        MODE_QUIET
    } mode_e;
endpackage

// File: rtl/sirq_slot_map.sv
module sirq_slot_map
    import sirq_pkg::*;
(
    input  logic [ISA_LINES-1:0] isa_irq,
    input  logic                 iochk_req,
    input  logic [PCI_LINES-1:0] pci_int,
    input  logic                 tie_all,
    input  logic                 cb_tie,
    input  logic [STEP_W-1:0]    step,
    output logic [SLOTS-1:0]     slot_vec
);
    logic [PCI_LINES-1:0] merged;
    logic [PCI_LINES-1:0] rotated;

    // merge network: tie_all wins over socket merge
    always_comb begin
        merged = pci_int;
        if (tie_all) begin
            merged    = '0;
            merged[0] = |pci_int;
        end else if (cb_tie) begin
            merged[0] = pci_int[0] | pci_int[1];
            merged[1] = 1'b0;
        end
    end

    // frame j takes merged interrupt (j - step) mod 4
    genvar j;
    generate
        for (j = 0; j < PCI_LINES; j++) begin : g_rot
            localparam logic [STEP_W-1:0] POS = STEP_W'(j);
            assign rotated[j] = merged[POS - step];
        end
    endgenerate

    assign slot_vec = {rotated, iochk_req, isa_irq};
endmodule

// File: rtl/sirq_frame_track.sv
module sirq_frame_track
    import sirq_pkg::*;
#(
    parameter int MIN_START  = 4,
    parameter int CNT_W      = 4,
    parameter int QUIET_STOP = 2,
    parameter int CONT_STOP  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    output trk_state_e        state,
    output phase_e            phase,
    output logic [SLOT_W-1:0] slot,
    output mode_e             mode,
    output logic              start_ev,
    output logic              line_idle
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [CNT_W-1:0]  START_MIN = CNT_W'(MIN_START);
    localparam logic [CNT_W-1:0]  STOP_Q    = CNT_W'(QUIET_STOP);
    localparam logic [CNT_W-1:0]  STOP_C    = CNT_W'(CONT_STOP);

    typedef struct packed {
        trk_state_e        st;
        phase_e            ph;
        logic [SLOT_W-1:0] slot;
        logic [CNT_W-1:0]  lows;
        mode_e             mode;
    } trk_t;

    trk_t trk_d, trk_q;
    logic start_d;

    always_comb begin
        trk_d   = trk_q;
        start_d = 1'b0;
        unique case (trk_q.st)
            TRK_IDLE: begin
                if (!line_in) begin
                    if (trk_q.lows != '1) trk_d.lows = trk_q.lows + 1'b1;
                end else begin
                    trk_d.lows = '0;
                    if (trk_q.lows >= START_MIN) begin
                        start_d  = 1'b1;
                        trk_d.st = TRK_START_TA;
                    end
                end
            end
            TRK_START_TA: begin
                trk_d.st   = TRK_DATA;
                trk_d.ph   = PH_SAMPLE;
                trk_d.slot = '0;
            end
            TRK_DATA: begin
                unique case (trk_q.ph)
                    PH_SAMPLE:  trk_d.ph = PH_RECOVER;
                    PH_RECOVER: trk_d.ph = PH_TURN;
                    default: begin
                        trk_d.ph = PH_SAMPLE;
                        if (trk_q.slot == LAST_SLOT) begin
                            trk_d.st   = TRK_STOP;
                            trk_d.lows = '0;
                        end else begin
                            trk_d.slot = trk_q.slot + 1'b1;
                        end
                    end
                endcase
            end
            default: begin
                if (!line_in) begin
                    if (trk_q.lows != '1) trk_d.lows = trk_q.lows + 1'b1;
                end else if (trk_q.lows != '0) begin
                    if (trk_q.lows == STOP_Q)      trk_d.mode = MODE_QUIET;
                    else if (trk_q.lows == STOP_C) trk_d.mode = MODE_CONT;
                    trk_d.st   = TRK_IDLE;
                    trk_d.lows = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q.st   <= TRK_IDLE;
            trk_q.ph   <= PH_SAMPLE;
            trk_q.slot <= '0;
            trk_q.lows <= '0;
            trk_q.mode <= MODE_CONT;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign state     = trk_q.st;
    assign phase     = trk_q.ph;
    assign slot      = trk_q.slot;
    assign mode      = trk_q.mode;
    assign start_ev  = start_d;
    assign line_idle = (trk_q.st == TRK_IDLE) && (trk_q.lows == '0);

    // R3
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st == TRK_DATA) |-> (trk_q.slot <= LAST_SLOT));

    // R2
    start_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st == TRK_START_TA) |=>
            (trk_q.st == TRK_DATA && trk_q.slot == '0 && trk_q.ph == PH_SAMPLE));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st != TRK_STOP) |=> $stable(trk_q.mode));
endmodule

// File: rtl/sirq_drive.sv
module sirq_drive
    import sirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  trk_state_e        state,
    input  phase_e            phase,
    input  logic [SLOT_W-1:0] slot,
    input  mode_e             mode,
    input  logic              start_ev,
    input  logic              line_idle,
    input  logic [SLOTS-1:0]  slot_vec,
    output logic              line_oe,
    output logic              line_out
);
    typedef struct packed {
        logic [SLOTS-1:0] snap;
        logic             req;
        logic             req_done;
    } drv_t;

    drv_t drv_d, drv_q;
    logic own;
    logic slot_drive;

    always_comb begin
        drv_d     = drv_q;
        drv_d.req = 1'b0;
        if (start_ev) begin
            drv_d.snap     = slot_vec;
            drv_d.req_done = 1'b0;
        end else if (line_idle && line_in && mode == MODE_QUIET &&
                     !drv_q.req_done && !drv_q.req && slot_vec != drv_q.snap) begin
            drv_d.req      = 1'b1;
            drv_d.req_done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q.snap     <= '0;
            drv_q.req      <= 1'b0;
            drv_q.req_done <= 1'b0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign own        = (slot < SLOT_W'(SLOTS)) ? drv_q.snap[slot] : 1'b0;
    assign slot_drive = (state == TRK_DATA) && own && (phase != PH_TURN);
    assign line_oe    = slot_drive | drv_q.req;
    assign line_out   = slot_drive && (phase == PH_RECOVER);

    // R7
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_q.req |=> !drv_q.req);

    // R8
    req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_q.req |-> (mode == MODE_QUIET));

    // R4
    turn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRK_DATA && phase == PH_TURN) |-> !line_oe);
endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
    import sirq_pkg::*;
#(
    parameter int MIN_START  = 4,
    parameter int CNT_W      = 4,
    parameter int QUIET_STOP = 2,
    parameter int CONT_STOP  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_in,
    input  logic [ISA_LINES-1:0] isa_irq,
    input  logic                 iochk_req,
    input  logic [PCI_LINES-1:0] pci_int,
    input  logic                 tie_all,
    input  logic                 cb_tie,
    input  logic [STEP_W-1:0]    step,
    output logic                 line_oe,
    output logic                 line_out
);
    logic [SLOTS-1:0]  slot_vec;
    trk_state_e        state;
    phase_e            phase;
    logic [SLOT_W-1:0] slot;
    mode_e             mode;
    logic              start_ev;
    logic              line_idle;

    sirq_slot_map map_i (
        .isa_irq  (isa_irq),
        .iochk_req(iochk_req),
        .pci_int  (pci_int),
        .tie_all  (tie_all),
        .cb_tie   (cb_tie),
        .step     (step),
        .slot_vec (slot_vec)
    );

    sirq_frame_track #(
        .MIN_START (MIN_START),
        .CNT_W     (CNT_W),
        .QUIET_STOP(QUIET_STOP),
        .CONT_STOP (CONT_STOP)
    ) track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .state    (state),
        .phase    (phase),
        .slot     (slot),
        .mode     (mode),
        .start_ev (start_ev),
        .line_idle(line_idle)
    );

    sirq_drive drive_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .state    (state),
        .phase    (phase),
        .slot     (slot),
        .mode     (mode),
        .start_ev (start_ev),
        .line_idle(line_idle),
        .slot_vec (slot_vec),
        .line_oe  (line_oe),
        .line_out (line_out)
    );
endmodule

// File: tb/sirq_agent_tb_top.sv
module sirq_agent_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_in = 1'b1;
    logic [15:0] isa_irq = '0;
    logic        iochk_req = 1'b0;
    logic [3:0]  pci_int = '0;
    logic        tie_all = 1'b0;
    logic        cb_tie = 1'b0;
    logic [1:0]  step = '0;
    logic        line_oe;
    logic        line_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sirq_agent dut_i (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .isa_irq(isa_irq),
        .iochk_req(iochk_req), .pci_int(pci_int), .tie_all(tie_all),
        .cb_tie(cb_tie), .step(step), .line_oe(line_oe), .line_out(line_out)
    );

    typedef struct packed {
        logic [15:0] isa;
        logic        iochk;
        logic [3:0]  pci;
        logic        tall;
        logic        cbt;
        logic [1:0]  stp;
        logic [3:0]  width;
        logic [20:0] expv;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'h0001, 1'b0, 4'b0000, 1'b0, 1'b0, 2'd0, 4'd4, 21'h000001}, // R3 IRQ0, start 4
        '{16'h8004, 1'b1, 4'b0000, 1'b0, 1'b0, 2'd0, 4'd8, 21'h018004}, // R3 SMI/IRQ15/IOCHCK, start 8
        '{16'h0000, 1'b0, 4'b0101, 1'b0, 1'b0, 2'd0, 4'd5, 21'h0A0000}, // R3 INTA/INTC
        '{16'h0000, 1'b0, 4'b0001, 1'b0, 1'b0, 2'd1, 4'd6, 21'h040000}, // R11 step 1
        '{16'h0000, 1'b0, 4'b1000, 1'b0, 1'b0, 2'd3, 4'd7, 21'h080000}, // R11 step 3
        '{16'h0000, 1'b0, 4'b0100, 1'b1, 1'b0, 2'd0, 4'd5, 21'h020000}, // R9 merge all
        '{16'h0000, 1'b0, 4'b0010, 1'b0, 1'b1, 2'd0, 4'd4, 21'h020000}, // R10 socket merge
        '{16'h0000, 1'b0, 4'b1010, 1'b0, 1'b1, 2'd0, 4'd6, 21'h120000}, // R10 INTD passes
        '{16'h0000, 1'b0, 4'b1000, 1'b1, 1'b0, 2'd2, 4'd7, 21'h080000}, // R9 with R11 step 2
        '{16'hFFFF, 1'b1, 4'b1111, 1'b0, 1'b0, 2'd0, 4'd5, 21'h1FFFFF}, // R4 all frames
        '{16'h0000, 1'b0, 4'b0011, 1'b0, 1'b1, 2'd1, 4'd8, 21'h040000}  // R10 with step 1
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic run_cycle(input int w, input int stopw, input bit mid,
                             input logic [15:0] mid_isa,
                             output logic [20:0] seen, output int bad);
        seen = '0;
        bad  = 0;
        @(negedge clk);
        line_in = 1'b0;
        repeat (w) @(negedge clk);
        line_in = 1'b1;
        @(negedge clk);
        if (line_oe) bad++;
        for (int k = 0; k < 21; k++) begin
            for (int p = 0; p < 3; p++) begin
                @(negedge clk);
                if (mid && k == 5 && p == 0) isa_irq = mid_isa;
                if (p == 0) begin
                    if (line_oe) begin
                        if (!line_out) seen[k] = 1'b1;
                        else bad++;
                    end
                end else if (p == 1) begin
                    if (seen[k]) begin
                        if (!(line_oe && line_out)) bad++;
                    end else if (line_oe) bad++;
                end else begin
                    if (line_oe) bad++;
                end
            end
        end
        @(negedge clk);
        line_in = 1'b0;
        repeat (stopw) @(negedge clk);
        line_in = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic watch(input int n, output int lows, output int highs);
        lows = 0;
        highs = 0;
        repeat (n) begin
            @(negedge clk);
            if (line_oe) begin
                if (line_out) highs++;
                else lows++;
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [20:0] seen;
        int bad, lows, highs, oe_cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_oe == 1'b0, "R1 reset drive", {31'd0, line_oe}, 32'd0);
        isa_irq = 16'h00FF;
        watch(10, lows, highs);
        chk(lows + highs == 0, "R1 continuous after reset", lows + highs, 0);

        for (int v = 0; v < NV; v++) begin
            isa_irq   = VECS[v].isa;
            iochk_req = VECS[v].iochk;
            pci_int   = VECS[v].pci;
            tie_all   = VECS[v].tall;
            cb_tie    = VECS[v].cbt;
            step      = VECS[v].stp;
            run_cycle(int'(VECS[v].width), 3, 1'b0, 16'h0, seen, bad);
            chk(seen == VECS[v].expv, $sformatf("R3 R2 vector %0d frames", v),
                {11'd0, seen}, {11'd0, VECS[v].expv});
            chk(bad == 0, $sformatf("R4 vector %0d drive pattern", v), bad, 0);
        end
        tie_all = 1'b0; cb_tie = 1'b0; step = '0; pci_int = '0; iochk_req = 1'b0;

        // R2 short start frame
        isa_irq = 16'hFFFF;
        @(negedge clk);
        line_in = 1'b0;
        repeat (3) @(negedge clk);
        line_in = 1'b1;
        oe_cnt = 0;
        repeat (80) begin
            @(negedge clk);
            if (line_oe) oe_cnt++;
        end
        chk(oe_cnt == 0, "R2 three-low start ignored", oe_cnt, 0);

        // R5 snapshot
        isa_irq = 16'h0008;
        run_cycle(4, 3, 1'b1, 16'h0408, seen, bad);
        chk(seen == 21'h000008, "R5 snapshot", {11'd0, seen}, 32'h8);

        // R6 stop 2 then R7 request
        isa_irq = 16'h0001;
        run_cycle(5, 2, 1'b0, 16'h0, seen, bad);
        chk(seen == 21'h000001, "R6 quiet cycle frames", {11'd0, seen}, 32'h1);
        isa_irq = 16'h0002;
        watch(10, lows, highs);
        chk(lows == 1 && highs == 0, "R7 one-clock request", lows * 16 + highs, 16);
        isa_irq = 16'h0003;
        watch(10, lows, highs);
        chk(lows + highs == 0, "R7 no repeat request", lows + highs, 0);

        // R6 stop 1 keeps quiet
        run_cycle(4, 1, 1'b0, 16'h0, seen, bad);
        chk(seen == 21'h000003, "R6 frames before stop 1", {11'd0, seen}, 32'h3);
        isa_irq = 16'h0000;
        watch(10, lows, highs);
        chk(lows == 1 && highs == 0, "R6 mode kept after stop 1", lows * 16 + highs, 16);

        // R6 stop 3 back to continuous, R8 no request
        run_cycle(6, 3, 1'b0, 16'h0, seen, bad);
        chk(bad == 0, "R4 empty cycle no drive", bad, 0);
        isa_irq = 16'h0001;
        watch(10, lows, highs);
        chk(lows + highs == 0, "R8 continuous no request", lows + highs, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule